// File: doc/BRIEF.md
# Cache Tag Store with Comparator

This block is the tag side of a direct-mapped cache. Every entry keeps a tag of `TAG_W` bits (12 by default) and three status bits. With `ADDR_W` = 14 the store reaches 16K entries. The default is 10 address bits, which keeps elaboration small. A lookup is purely combinational. The address selects an entry, and the stored tag is compared with the incoming tag to give a hit flag. The stored tag and status also appear on read outputs. Tag writes, status writes and the bulk invalidate happen only at a rising clock edge.

The status bits work in one of two modes, set by a mode input. In cache mode they are valid, dirty and write-through, and the valid bit qualifies the hit. In generic mode they are three plain user bits, and the hit is a bare tag compare. The store also builds an active-low transfer acknowledge. The sources are:
- a read hit;
- a write hit on an entry that is not write-through;
- an external acknowledge input.

A force input holds the acknowledge inactive. Two chip selects gate access to the store, and a power-down input freezes it. Output enables are modelled as "driven" flags, not as tri-state pins.

Top module: `ctag_store`

## Requirements
- R1: When both chip selects are active (`sel_a_n` low, `sel_b` high), `pwr_dn` is low and `tag_wr_n` is low at a rising edge, `tag_in` is stored at `addr`. `tag_out` shows the stored tag of the addressed entry combinationally.
- R2: A tag write leaves the entry's status bits unchanged. A status write (`stat_wr_n` low) leaves the entry's tag unchanged.
- R3: The status word has the valid bit at bit 0, the dirty bit at bit 1 and the write-through bit at bit 2. `stat_out` shows the addressed entry's status combinationally, and a status write stores `stat_in`.
- R4: In cache mode (`gen_mode` low), `match` is high only when the device is selected, the stored tag equals `tag_in` and the entry's valid bit is 1.
- R5: In generic mode (`gen_mode` high), `match` is high when the device is selected and the stored tag equals `tag_in`, whatever the status bits hold.
- R6: If `rst_n` is low at a rising edge, the status bits of every entry become 0 in that one edge and tags are kept. This clear wins over a status write in the same cycle.
- R7: While either chip select is inactive, writes are ignored, `match` is low, and `tag_out_vld` and `stat_out_vld` are low.
- R8: `tag_out_vld` is high only when the device is selected and `tag_oe_n` is low. `stat_out_vld` is high only when the device is selected and `stat_oe_n` is low. `ack_vld` is high when `ack_oe_n` is low and `pwr_dn` is low.
- R9: In cache mode, `ack_n` goes low on a hit with `cpu_rd` high (read). It also goes low on a hit with `cpu_rd` low (write) when the write-through bit is 0. In generic mode a hit alone never asserts `ack_n`.
- R10: `ack_n` goes low when `ext_ack_n` is low. `ack_force_hi` high holds `ack_n` high over every other source.
- R11: While `pwr_dn` is high, writes are blocked, `match` is low, and all three driven flags are low. Stored contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and the bulk clear act on its rising edge |
| rst_n | input | 1 | Active-low synchronous clear of every status word |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| pwr_dn | input | 1 | Power-down: blocks writes, reports outputs undriven |
| gen_mode | input | 1 | 0 = cache status meanings, 1 = generic user bits |
| addr | input | ADDR_W | Entry index |
| tag_in | input | TAG_W | Tag to compare and to write |
| stat_in | input | 3 | Status word to write |
| tag_wr_n | input | 1 | Tag field write enable, active low |
| stat_wr_n | input | 1 | Status field write enable, active low |
| tag_oe_n | input | 1 | Tag readout enable, active low |
| stat_oe_n | input | 1 | Status readout enable, active low |
| ack_oe_n | input | 1 | Acknowledge output enable, active low |
| cpu_rd | input | 1 | Processor direction: 1 read, 0 write |
| ext_ack_n | input | 1 | External acknowledge request, active low |
| ack_force_hi | input | 1 | Forces the acknowledge inactive |
| match | output | 1 | Hit flag |
| tag_out | output | TAG_W | Stored tag of the addressed entry |
| tag_out_vld | output | 1 | Tag readout is driven |
| stat_out | output | 3 | Stored status of the addressed entry |
| stat_out_vld | output | 1 | Status readout is driven |
| ack_n | output | 1 | Transfer acknowledge, active low |
| ack_vld | output | 1 | Acknowledge output is driven |

## Verification
`match`, `ack_n`, the readouts and the driven flags depend only on the inputs in the same cycle. A write or clear applied at a rising edge becomes visible from that edge onward. The bench therefore changes inputs at a falling edge and samples one nanosecond later. It folds each write or clear into its model only after the rising edge that commits it. A read issued right after a write thus expects the new contents, and the sample taken during the write cycle still expects the old contents.

// File: rtl/ctag_pkg.sv
package ctag_pkg;

    localparam int STAT_W = 3;

    // Bit positions inside a status word (valid is the least significant bit)
    localparam int ST_VALID = 0;
    localparam int ST_DIRTY = 1;
    localparam int ST_WT    = 2;

    typedef struct packed {
        logic wt;
        logic dirty;
        logic valid;
    } stat_t;

    typedef enum logic {
        MODE_CACHE   = 1'b0,
        MODE_GENERIC = 1'b1
    } mode_e;

endpackage

// File: rtl/ctag_tag_ram.sv
module ctag_tag_ram #(
    parameter int ADDR_W = 10,
    parameter int TAG_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [TAG_W-1:0]  wdata,
    output logic [TAG_W-1:0]  rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [TAG_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    assign rdata = mem_q[addr];

    // R1
    tag_write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ($stable(addr) |-> (rdata == $past(wdata))));

endmodule

// File: rtl/ctag_status_bank.sv
module ctag_status_bank
    import ctag_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  stat_t             wdata,
    output stat_t             rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    stat_t st_d [DEPTH];
    stat_t st_q [DEPTH];

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                st_d[i] = '0;
            end
        end else if (we) begin
            st_d[addr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rdata = st_q[addr];

    // R6
    bulk_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (rdata == '0));

    // R2
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !we) |=> (st_q[$past(addr)] == $past(st_q[addr])));

    // R3
    status_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ($stable(addr) |-> (rdata == $past(wdata))));

endmodule

// File: rtl/ctag_hit_unit.sv
module ctag_hit_unit
    import ctag_pkg::*;
#(
    parameter int TAG_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  mode_e            mode,
    input  logic [TAG_W-1:0] tag_rd,
    input  logic [TAG_W-1:0] tag_in,
    input  logic             valid,
    input  logic             wt,
    input  logic             cpu_rd,
    input  logic             ext_ack_n,
    input  logic             ack_force_hi,
    output logic             match,
    output logic             ack_assert
);
    logic tag_eq;
    logic qual;
    logic int_hit;

    always_comb begin
        tag_eq     = (tag_rd == tag_in);
        qual       = (mode == MODE_GENERIC) || valid;
        match      = sel && tag_eq && qual;
        int_hit    = (mode == MODE_CACHE) && match && (cpu_rd || !wt);
        ack_assert = !ack_force_hi && (int_hit || !ext_ack_n);
    end

    // R4
    match_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_CACHE) && match) |-> valid);

    // R7
    match_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> !match);

    // R10
    force_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_force_hi |-> !ack_assert);

    // R9
    wt_write_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wt && !cpu_rd && ext_ack_n) |-> !ack_assert);

endmodule

// File: rtl/ctag_store.sv
module ctag_store
    import ctag_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int TAG_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              pwr_dn,
    input  logic              gen_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [TAG_W-1:0]  tag_in,
    input  logic [2:0]        stat_in,
    input  logic              tag_wr_n,
    input  logic              stat_wr_n,
    input  logic              tag_oe_n,
    input  logic              stat_oe_n,
    input  logic              ack_oe_n,
    input  logic              cpu_rd,
    input  logic              ext_ack_n,
    input  logic              ack_force_hi,
    output logic              match,
    output logic [TAG_W-1:0]  tag_out,
    output logic              tag_out_vld,
    output logic [2:0]        stat_out,
    output logic              stat_out_vld,
    output logic              ack_n,
    output logic              ack_vld
);
    logic             sel;
    logic             tag_we;
    logic             stat_we;
    logic [TAG_W-1:0] tag_rd;
    stat_t            stat_rd;
    logic             ack_assert;
    mode_e            mode;

    always_comb begin
        sel     = !sel_a_n && sel_b && !pwr_dn;
        tag_we  = sel && !tag_wr_n;
        stat_we = sel && !stat_wr_n;
        mode    = mode_e'(gen_mode);
    end

    ctag_tag_ram #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_tags (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tag_we),
        .addr  (addr),
        .wdata (tag_in),
        .rdata (tag_rd)
    );

    ctag_status_bank #(.ADDR_W(ADDR_W)) u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (stat_we),
        .addr  (addr),
        .wdata (stat_t'(stat_in)),
        .rdata (stat_rd)
    );

    ctag_hit_unit #(.TAG_W(TAG_W)) u_hit (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel          (sel),
        .mode         (mode),
        .tag_rd       (tag_rd),
        .tag_in       (tag_in),
        .valid        (stat_rd.valid),
        .wt           (stat_rd.wt),
        .cpu_rd       (cpu_rd),
        .ext_ack_n    (ext_ack_n),
        .ack_force_hi (ack_force_hi),
        .match        (match),
        .ack_assert   (ack_assert)
    );

    always_comb begin
        tag_out      = tag_rd;
        stat_out     = stat_rd;
        tag_out_vld  = sel && !tag_oe_n;
        stat_out_vld = sel && !stat_oe_n;
        ack_n        = !ack_assert;
        ack_vld      = !ack_oe_n && !pwr_dn;
    end

    // R11
    power_down_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |-> (!match && !tag_out_vld && !stat_out_vld && !ack_vld));

    // R11
    power_down_keeps_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_dn && $stable(addr)) |=> (tag_out == $past(tag_out)));

    // R8
    tag_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tag_oe_n |-> !tag_out_vld);

endmodule

// File: tb/ctag_store_bench.sv
module ctag_store_bench;
    localparam int ADDR_W = 4;
    localparam int TAG_W  = 12;
    localparam int DEPTH  = 1 << ADDR_W;

    typedef struct {
        string            req;
        logic             match;
        logic             ack_n;
        logic             ack_vld;
        logic             tag_vld;
        logic             stat_vld;
        logic             cmp_tag;
        logic [TAG_W-1:0] tag;
        logic [2:0]       stat;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n, sel_a_n, sel_b, pwr_dn, gen_mode;
    logic [ADDR_W-1:0] addr;
    logic [TAG_W-1:0]  tag_in;
    logic [2:0]        stat_in;
    logic tag_wr_n, stat_wr_n, tag_oe_n, stat_oe_n, ack_oe_n;
    logic cpu_rd, ext_ack_n, ack_force_hi;
    logic match, tag_out_vld, stat_out_vld, ack_n, ack_vld;
    logic [TAG_W-1:0] tag_out;
    logic [2:0]       stat_out;

    always #5 clk = ~clk;

    ctag_store #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_ctag_store (
        .clk(clk), .rst_n(rst_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
        .pwr_dn(pwr_dn), .gen_mode(gen_mode), .addr(addr), .tag_in(tag_in),
        .stat_in(stat_in), .tag_wr_n(tag_wr_n), .stat_wr_n(stat_wr_n),
        .tag_oe_n(tag_oe_n), .stat_oe_n(stat_oe_n), .ack_oe_n(ack_oe_n),
        .cpu_rd(cpu_rd), .ext_ack_n(ext_ack_n), .ack_force_hi(ack_force_hi),
        .match(match), .tag_out(tag_out), .tag_out_vld(tag_out_vld),
        .stat_out(stat_out), .stat_out_vld(stat_out_vld),
        .ack_n(ack_n), .ack_vld(ack_vld)
    );

    logic [TAG_W-1:0] tag_m   [DEPTH];
    logic             tag_k   [DEPTH];
    logic [2:0]       st_m    [DEPTH];
    exp_t             exp_q[$];
    event             chk_ev;
    int               compared   = 0;
    int               mismatched = 0;
    bit               done       = 1'b0;

    task automatic report(string req, string what, int got, int exp);
        compared++;
        if (got != exp) begin
            mismatched++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    // Monitor: pops one expected item per sample event and compares
    initial begin
        forever begin
            exp_t e;
            @(chk_ev);
            e = exp_q.pop_front();
            report(e.req, "match", int'(match), int'(e.match));
            report(e.req, "ack_n", int'(ack_n), int'(e.ack_n));
            report(e.req, "ack_vld", int'(ack_vld), int'(e.ack_vld));
            report(e.req, "tag_out_vld", int'(tag_out_vld), int'(e.tag_vld));
            report(e.req, "stat_out_vld", int'(stat_out_vld), int'(e.stat_vld));
            if (e.stat_vld) report(e.req, "stat_out", int'(stat_out), int'(e.stat));
            if (e.cmp_tag)  report(e.req, "tag_out", int'(tag_out), int'(e.tag));
        end
    end

    task automatic model_update();
        logic s;
        s = !sel_a_n && sel_b && !pwr_dn;
        if (s && !tag_wr_n) begin
            tag_m[addr] = tag_in;
            tag_k[addr] = 1'b1;
        end
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) st_m[i] = 3'b000;
        end else if (s && !stat_wr_n) begin
            st_m[addr] = stat_in;
        end
    endtask

    // Driver: called just after a falling edge; pushes the expectation, then commits at the rising edge
    task automatic step(string req);
        exp_t e;
        logic s, hit;
        #1;
        s          = !sel_a_n && sel_b && !pwr_dn;
        e.req      = req;
        e.tag      = tag_m[addr];
        e.stat     = st_m[addr];
        e.match    = s && tag_k[addr] && (tag_m[addr] == tag_in) && (gen_mode || st_m[addr][0]);
        hit        = !gen_mode && e.match && (cpu_rd || !st_m[addr][2]);
        e.ack_n    = !(!ack_force_hi && (hit || !ext_ack_n));
        e.ack_vld  = !ack_oe_n && !pwr_dn;
        e.tag_vld  = s && !tag_oe_n;
        e.stat_vld = s && !stat_oe_n;
        e.cmp_tag  = e.tag_vld && tag_k[addr];
        exp_q.push_back(e);
        -> chk_ev;
        #1;
        @(posedge clk);
        model_update();
    endtask

    task automatic idle();
        rst_n = 1'b1; sel_a_n = 1'b0; sel_b = 1'b1; pwr_dn = 1'b0; gen_mode = 1'b0;
        tag_wr_n = 1'b1; stat_wr_n = 1'b1; tag_oe_n = 1'b0; stat_oe_n = 1'b0;
        ack_oe_n = 1'b0; cpu_rd = 1'b1; ext_ack_n = 1'b1; ack_force_hi = 1'b0;
        stat_in = 3'b000;
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            tag_m[i] = '0; tag_k[i] = 1'b0; st_m[i] = 3'b000;
        end
        idle();
        sel_a_n = 1'b1; sel_b = 1'b0; rst_n = 1'b0; addr = '0; tag_in = '0;
        repeat (3) begin
            @(posedge clk);
            model_update();
        end

        // R6: reset state
        @(negedge clk); idle(); addr = 4'd3; step("R6 reset state");

        // R1 / R3: write tag and status (valid) at entry 5
        @(negedge clk); idle(); addr = 4'd5; tag_in = 12'hABC; stat_in = 3'b001;
        tag_wr_n = 1'b0; stat_wr_n = 1'b0; step("R1 write cycle");
        @(negedge clk); idle(); addr = 4'd5; tag_in = 12'hABC; step("R1 R4 readback hit");
        @(negedge clk); idle(); addr = 4'd5; tag_in = 12'hABD; step("R4 tag miss");

        // R2: tag-only and status-only writes
        @(negedge clk); idle(); addr = 4'd5; tag_in = 12'h123; tag_wr_n = 1'b0; step("R2 tag-only write");
        @(negedge clk); idle(); addr = 4'd5; tag_in = 12'h123; step("R2 status kept");
        @(negedge clk); idle(); addr = 4'd5; tag_in = 12'h123; stat_in = 3'b011; stat_wr_n = 1'b0;
        step("R2 status-only write");
        @(negedge clk); idle(); addr = 4'd5; tag_in = 12'h123; step("R2 R3 tag kept, status order");

        // R4 / R5: invalid entry, then generic mode
        @(negedge clk); idle(); addr = 4'd6; tag_in = 12'h055; stat_in = 3'b110;
        tag_wr_n = 1'b0; stat_wr_n = 1'b0; step("R1 write entry 6");
        @(negedge clk); idle(); addr = 4'd6; tag_in = 12'h055; step("R4 invalid no match");
        @(negedge clk); idle(); addr = 4'd6; tag_in = 12'h055; gen_mode = 1'b1; step("R5 generic match");
        @(negedge clk); idle(); addr = 4'd6; tag_in = 12'h055; gen_mode = 1'b1; cpu_rd = 1'b0;
        step("R9 generic hit gives no ack");

        // R9 / R10: acknowledge
        @(negedge clk); idle(); addr = 4'd5; tag_in = 12'h123; step("R9 read hit ack");
        @(negedge clk); idle(); addr = 4'd5; tag_in = 12'h123; cpu_rd = 1'b0; step("R9 write hit copy-back ack");
        @(negedge clk); idle(); addr = 4'd5; tag_in = 12'h123; stat_in = 3'b101; stat_wr_n = 1'b0;
        step("R3 set write-through");
        @(negedge clk); idle(); addr = 4'd5; tag_in = 12'h123; cpu_rd = 1'b0; step("R9 write-through write hit no ack");
        @(negedge clk); idle(); addr = 4'd5; tag_in = 12'h123; cpu_rd = 1'b0; ext_ack_n = 1'b0;
        step("R10 external ack");
        @(negedge clk); idle(); addr = 4'd5; tag_in = 12'h123; ext_ack_n = 1'b0; ack_force_hi = 1'b1;
        step("R10 force high");
        @(negedge clk); idle(); addr = 4'd9; tag_in = 12'h001; step("R9 miss no ack");

        // R7: chip selects
        @(negedge clk); idle(); sel_b = 1'b0; addr = 4'd5; tag_in = 12'h777; stat_in = 3'b000;
        tag_wr_n = 1'b0; stat_wr_n = 1'b0; step("R7 sel_b inactive");
        @(negedge clk); idle(); sel_a_n = 1'b1; addr = 4'd5; tag_in = 12'h123; tag_wr_n = 1'b0;
        step("R7 sel_a_n inactive");
        @(negedge clk); idle(); addr = 4'd5; tag_in = 12'h123; step("R7 writes ignored");

        // R8: output enables
        @(negedge clk); idle(); addr = 4'd5; tag_in = 12'h123; tag_oe_n = 1'b1; step("R8 tag oe off");
        @(negedge clk); idle(); addr = 4'd5; tag_in = 12'h123; stat_oe_n = 1'b1; ack_oe_n = 1'b1;
        step("R8 status and ack oe off");

        // R11: power down
        @(negedge clk); idle(); pwr_dn = 1'b1; addr = 4'd5; tag_in = 12'h123; tag_wr_n = 1'b0;
        stat_wr_n = 1'b0; stat_in = 3'b000; step("R11 power down quiet");
        @(negedge clk); idle(); addr = 4'd5; tag_in = 12'h123; step("R11 contents kept");

        // R6: clear wins over a status write
        @(negedge clk); idle(); rst_n = 1'b0; addr = 4'd5; tag_in = 12'h123; stat_in = 3'b111;
        stat_wr_n = 1'b0; step("R6 clear with status write");
        @(negedge clk); idle(); addr = 4'd5; tag_in = 12'h123; step("R6 entry 5 cleared, tag kept");
        @(negedge clk); idle(); addr = 4'd6; tag_in = 12'h055; step("R6 entry 6 cleared");
        @(negedge clk); idle(); addr = 4'd6; tag_in = 12'h055; gen_mode = 1'b1; step("R5 generic after clear");

        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog (all requirements): got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule